// File: doc/BRIEF.md
# Low-Power Pin Wake-Up Detector

The detector observes a port of I/O pins and records activity on them as per-pin flag bits. In normal operation each enabled pin flags on one edge, the one its edge-select bit picks, and the flags drive a single port interrupt line. When a low-power-mode flag is raised, the block switches to wake detection. Any edge on an enabled pin then flags that pin and emits a one-cycle wake request. Pins whose function-select pair is 11 are excluded from wake detection.

Pin inputs are resynchronised by a flop chain before edge detection. On entry to low-power mode the pin configuration is frozen in shadow registers. Wake decisions use these frozen copies, whatever happens on the configuration inputs until the mode is left. Software clears flags by writing ones through a clear-flag write port.

Top module: `pin_wake_detector`

## Requirements
- R1: After reset all flag bits, the port interrupt line and the wake request are 0.
- R2: In normal mode an enabled pin sets its flag on a rising edge when its edge-select bit is 0, and on a falling edge when it is 1. The opposite edge leaves the flag alone. The flag becomes visible after the third rising clock edge that follows the pin change.
- R3: A pin whose enable bit is 0 never sets its flag.
- R4: Writing the clear port with write-enable high clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: If a qualifying edge sets a flag in the same cycle that a clear targets that flag, the flag stays 1.
- R6: The port interrupt line is 1 exactly when some flag is 1 and that pin's enable bit is 1.
- R7: In normal mode the wake request stays 0.
- R8: In low-power mode a rising or a falling edge on an enabled pin sets its flag and raises the wake request, whatever the edge-select bit. The wake request is high for a single cycle.
- R9: In low-power mode a pin whose function-select pair (sel1,sel0) is 11 neither sets its flag nor raises the wake request. Pairs 00, 01 and 10 do allow a wake.
- R10: The enable, edge-select and function-select bits in effect during low-power mode are those present when the mode was entered. Changes on those inputs are ignored until the mode is left.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pinIn | input | 8 | Asynchronous pin input levels |
| intEn | input | 8 | Per-pin enable |
| edgeSel | input | 8 | Per-pin edge select, 0 rising, 1 falling (normal mode) |
| funcSel0 | input | 8 | Per-pin function-select low bit |
| funcSel1 | input | 8 | Per-pin function-select high bit |
| lowPowerMode | input | 1 | 1 selects wake detection |
| flagClrWe | input | 1 | Clear-flag write strobe |
| flagClrData | input | 8 | Clear mask, 1 clears the flag |
| flagOut | output | 8 | Per-pin flag bits |
| portIrq | output | 1 | OR of enabled flags |
| wakeReq | output | 1 | One-cycle wake request |

## Verification
A corrupted synchronizer or previous-value register shows up at the ports as a flag on the wrong edge, or as a flag one cycle early or late. The bench pins this down by sampling both before and at the third clock edge after a pin change. A shadow register that loads when it should hold shows up only later, as a wake that a since-changed live input would have blocked or allowed. For that reason the live inputs are changed in the middle of a low-power session and the next edge is checked. A bad clear path leaves a stale flag visible on flagOut and portIrq one cycle after the write.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef struct packed {
    logic lpActive;
    logic loadCfg;
    logic clrWe;
  } pwdStrobe_t;

  localparam logic [1:0] SEL_NO_WAKE = 2'b11;
endpackage

// File: rtl/pwd_ctrl.sv
module pwd_ctrl #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                lowPowerMode,
  input  logic                flagClrWe,
  input  logic [NUM_PINS-1:0] hitVec,
  output pwd_pkg::pwdStrobe_t strobe,
  output logic                wakeReq
);
  logic lpModeQ;
  logic wakeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpModeQ <= 1'b0;
      wakeQ   <= 1'b0;
    end else begin
      lpModeQ <= lowPowerMode;
      wakeQ   <= lpModeQ & (|hitVec) & ~wakeQ;
    end
  end

  always_comb begin
    strobe.lpActive = lpModeQ;
    strobe.loadCfg  = ~lpModeQ;
    strobe.clrWe    = flagClrWe;
  end

  assign wakeReq = wakeQ;

  assert_wake_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wakeQ |=> !wakeQ);

  assert_no_wake_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wakeQ |-> $past(lpModeQ));
endmodule

// File: rtl/pwd_datapath.sv
module pwd_datapath #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  pwd_pkg::pwdStrobe_t strobe,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] intEn,
  input  logic [NUM_PINS-1:0] edgeSel,
  input  logic [NUM_PINS-1:0] funcSel0,
  input  logic [NUM_PINS-1:0] funcSel1,
  input  logic [NUM_PINS-1:0] flagClrData,
  output logic [NUM_PINS-1:0] hitVec,
  output logic [NUM_PINS-1:0] flagOut,
  output logic                portIrq
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] enQ, edgeQ, sel0Q, sel1Q;
  logic [NUM_PINS-1:0] effEn, effEdge, effSel0, effSel1;
  logic [NUM_PINS-1:0] riseVec, fallVec, clrMask;
  logic [NUM_PINS-1:0] flagQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enQ   <= '0;
      edgeQ <= '0;
      sel0Q <= '0;
      sel1Q <= '0;
    end else if (strobe.loadCfg) begin
      enQ   <= intEn;
      edgeQ <= edgeSel;
      sel0Q <= funcSel0;
      sel1Q <= funcSel1;
    end
  end

  assign effEn   = strobe.lpActive ? enQ   : intEn;
  assign effEdge = strobe.lpActive ? edgeQ : edgeSel;
  assign effSel0 = strobe.lpActive ? sel0Q : funcSel0;
  assign effSel1 = strobe.lpActive ? sel1Q : funcSel1;

  assign riseVec = syncQ[LAST] & ~prevQ;
  assign fallVec = ~syncQ[LAST] & prevQ;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic wakeOk;
    assign wakeOk = ({effSel1[i], effSel0[i]} != pwd_pkg::SEL_NO_WAKE);
    assign hitVec[i] = effEn[i] & (strobe.lpActive
                       ? ((riseVec[i] | fallVec[i]) & wakeOk)
                       : (effEdge[i] ? fallVec[i] : riseVec[i]));

    assert_flag_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flagQ[i]) |-> $past(effEn[i]));

    assert_flag_clear_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flagQ[i]) |-> $past(strobe.clrWe && flagClrData[i]));

    assert_no_wake_sel11_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flagQ[i]) && $past(strobe.lpActive))
        |-> $past({effSel1[i], effSel0[i]} != pwd_pkg::SEL_NO_WAKE));
  end

  assign clrMask = strobe.clrWe ? flagClrData : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flagQ <= '0;
    else        flagQ <= (flagQ & ~clrMask) | hitVec;
  end

  assign flagOut = flagQ;
  assign portIrq = |(flagQ & effEn);

  assert_cfg_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.lpActive && $past(strobe.lpActive))
      |-> ($stable(enQ) && $stable(edgeQ) && $stable(sel0Q) && $stable(sel1Q)));
endmodule

// File: rtl/pin_wake_detector.sv
module pin_wake_detector #(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] intEn,
  input  logic [NUM_PINS-1:0] edgeSel,
  input  logic [NUM_PINS-1:0] funcSel0,
  input  logic [NUM_PINS-1:0] funcSel1,
  input  logic                lowPowerMode,
  input  logic                flagClrWe,
  input  logic [NUM_PINS-1:0] flagClrData,
  output logic [NUM_PINS-1:0] flagOut,
  output logic                portIrq,
  output logic                wakeReq
);
  pwd_pkg::pwdStrobe_t strobe;
  logic [NUM_PINS-1:0] hitVec;

  pwd_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .lowPowerMode(lowPowerMode),
    .flagClrWe(flagClrWe), .hitVec(hitVec),
    .strobe(strobe), .wakeReq(wakeReq)
  );

  pwd_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .pinIn(pinIn), .intEn(intEn), .edgeSel(edgeSel),
    .funcSel0(funcSel0), .funcSel1(funcSel1), .flagClrData(flagClrData),
    .hitVec(hitVec), .flagOut(flagOut), .portIrq(portIrq)
  );

  assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    portIrq |-> (flagOut != '0));
endmodule

// File: tb/pin_wake_detector_tb.sv
module pin_wake_detector_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pinIn = '0, intEn = 8'hFF, edgeSel = '0, funcSel0 = '0, funcSel1 = '0;
  logic       lowPowerMode = 1'b0, flagClrWe = 1'b0;
  logic [7:0] flagClrData = '0;
  logic [7:0] flagOut;
  logic       portIrq, wakeReq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_wake_detector u_dut (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .intEn(intEn), .edgeSel(edgeSel),
    .funcSel0(funcSel0), .funcSel1(funcSel1), .lowPowerMode(lowPowerMode),
    .flagClrWe(flagClrWe), .flagClrData(flagClrData),
    .flagOut(flagOut), .portIrq(portIrq), .wakeReq(wakeReq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  // change pins at a falling edge, then stand just after the third rising edge
  task automatic toggle(input logic [7:0] mask);
    @(negedge clk) pinIn = pinIn ^ mask;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic clearFlags(input logic [7:0] mask);
    @(negedge clk) begin flagClrWe = 1'b1; flagClrData = mask; end
    @(negedge clk) begin flagClrWe = 1'b0; flagClrData = '0; end
  endtask

  task automatic tReset;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R1 flags", flagOut, 0);
    chk("R1 irq", portIrq, 0);
    chk("R1 wake", wakeReq, 0);
  endtask

  task automatic tNormalEdges;
    @(negedge clk) pinIn[0] = 1'b1;
    repeat (2) @(posedge clk);
    #1 chk("R2 not yet after two edges", flagOut[0], 0);
    @(posedge clk);
    #1 chk("R2 rising sets at third edge", flagOut[0], 1);
    chk("R7 no wake in normal", wakeReq, 0);
    chk("R6 irq up", portIrq, 1);
    clearFlags(8'h01);
    toggle(8'h01);
    chk("R2 falling ignored with sel 0", flagOut, 0);
    edgeSel[1] = 1'b1;
    toggle(8'h02);
    chk("R2 rising ignored with sel 1", flagOut, 0);
    toggle(8'h02);
    chk("R2 falling sets with sel 1", flagOut, 8'h02);
    chk("R7 no wake on falling", wakeReq, 0);
    clearFlags(8'hFF);
    edgeSel = '0;
  endtask

  task automatic tEnable;
    intEn[2] = 1'b0;
    toggle(8'h04);
    chk("R3 disabled pin no flag", flagOut, 0);
    chk("R3 disabled pin no irq", portIrq, 0);
    toggle(8'h04);
    intEn = 8'hFF;
  endtask

  task automatic tClear;
    toggle(8'h09);
    chk("R2 two pins set", flagOut, 8'h09);
    clearFlags(8'h01);
    chk("R4 only masked flag cleared", flagOut, 8'h08);
    intEn[3] = 1'b0;
    #1 chk("R6 flag without enable no irq", portIrq, 0);
    intEn[3] = 1'b1;
    #1 chk("R6 flag with enable irq", portIrq, 1);
    clearFlags(8'h00);
    chk("R4 zero mask keeps flags", flagOut, 8'h08);
    toggle(8'h09);
    clearFlags(8'hFF);
    chk("R4 all cleared", flagOut, 0);
  endtask

  task automatic tCollision;
    toggle(8'h10);
    toggle(8'h10);
    chk("R5 setup flag", flagOut, 8'h10);
    @(negedge clk) pinIn[4] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) begin flagClrWe = 1'b1; flagClrData = 8'h10; end
    @(posedge clk);
    #1 chk("R5 edge beats clear", flagOut, 8'h10);
    @(negedge clk) begin flagClrWe = 1'b0; flagClrData = '0; end
    toggle(8'h10);
    clearFlags(8'hFF);
    chk("R5 cleared afterwards", flagOut, 0);
  endtask

  task automatic tLowPower;
    // pin5 sel 00, pin6 01, pin7 10, pin3 11, pin2 disabled
    funcSel0 = 8'b0100_1000;
    funcSel1 = 8'b1000_1000;
    intEn    = 8'b1111_1011;
    edgeSel  = 8'b0000_0000;
    @(negedge clk) lowPowerMode = 1'b1;
    repeat (3) @(negedge clk);
    toggle(8'h20);
    chk("R8 rising wakes flag", flagOut, 8'h20);
    chk("R8 rising wakes", wakeReq, 1);
    @(posedge clk);
    #1 chk("R8 wake one cycle", wakeReq, 0);
    toggle(8'h20);
    chk("R8 falling wakes despite sel 0", wakeReq, 1);
    clearFlags(8'hFF);
    toggle(8'h40);
    chk("R9 sel 01 wakes", wakeReq, 1);
    chk("R9 sel 01 flag", flagOut, 8'h40);
    clearFlags(8'hFF);
    toggle(8'h80);
    chk("R9 sel 10 wakes", wakeReq, 1);
    clearFlags(8'hFF);
    toggle(8'h08);
    chk("R9 sel 11 no wake", wakeReq, 0);
    chk("R9 sel 11 no flag", flagOut, 0);
    toggle(8'h04);
    chk("R3 disabled pin no wake", wakeReq, 0);
    chk("R3 disabled pin no flag lp", flagOut, 0);
    // live configuration changes must not matter now
    intEn = 8'h00;
    funcSel0 = 8'hF7;
    funcSel1 = 8'hF7;
    toggle(8'h20);
    chk("R10 held config still wakes", wakeReq, 1);
    chk("R10 held enable gives irq", portIrq, 1);
    clearFlags(8'hFF);
    toggle(8'h08);
    chk("R10 held sel 11 still blocks", wakeReq, 0);
    chk("R10 held sel 11 no flag", flagOut, 0);
    @(negedge clk) lowPowerMode = 1'b0;
    funcSel0 = '0; funcSel1 = '0; intEn = 8'hFF;
    repeat (3) @(negedge clk);
    toggle(8'h01);
    chk("R7 back in normal no wake", wakeReq, 0);
    chk("R2 back in normal rising flag", flagOut, 8'h01);
  endtask

  initial begin
    tReset();
    tNormalEdges();
    tEnable();
    tClear();
    tCollision();
    tLowPower();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule